// File: doc/BRIEF.md
# UART Transmit Status and Request Logic

This block sits between the processor-facing write port of a UART transmitter and its serializer. It stores characters either in a single holding register or in a 16-deep transmit queue, chosen by a mode input. It hands each character to the serializer with a one-cycle load handshake and keeps track of whether the shift register is occupied. From that state it derives two status flags: a "transmitter idle" flag and a "send more data" request flag. The request flag feeds an interrupt line gated by an enable, and a DMA request line.

In single-register mode the request flag clears when the processor writes a character and sets again once that character has moved into the shift register. In queue mode the flag tracks queue emptiness: it clears on the first byte written and sets when the queue drains or is flushed. A write to a full queue is dropped without notice. A flush empties the queue but does not touch a character that is already being shifted out.

Top module: `uart_tx_status`

## Requirements
- R1: After synchronous reset the status byte `lsr` reads 8'h60 (bit 6 idle flag = 1, bit 5 request flag = 1, all other bits 0), `load_valid` is 0, and the block is in single-register mode.
- R2: `tx_empty` (also `lsr` bit 6) is 1 exactly when the active character store and the shift register are both empty, and 0 when either of them holds a character.
- R3: In single-register mode, a write clears `tx_req` (`lsr` bit 5) in the cycle after the write edge. It sets again after the edge at which the held character is loaded into the shift register, unless a write arrives in that same cycle.
- R4: In single-register mode, a write while the holding register is still full replaces its contents, and `load_data` then shows the newest character.
- R5: In queue mode, `tx_req` is 1 exactly when the queue is empty. It clears after the first accepted write and sets after the edge that pops or flushes the last entry.
- R6: In queue mode, the queue holds at most 16 characters and delivers them in write order. A write made while 16 are queued is discarded, even if a pop happens in the same cycle.
- R7: A `txf_clear` pulse in queue mode empties the queue, so `tx_req` is 1 in the next cycle. A write in the same cycle is discarded, and the shift register stays occupied. `txf_clear` has no effect in single-register mode.
- R8: `irq` equals `tx_req` AND `irq_en` combinationally, and `dma_req` equals `tx_req`, so `dma_req` drops in the same cycle that the request flag clears.
- R9: `load_valid` is 1 when the active store holds a character, the shift register is empty, and the mode input is unchanged. A `load_valid` cycle moves the head character into the shift register. The shift register stays occupied until a `shift_done` pulse, and `shift_done` while it is empty is ignored.
- R10: A cycle in which `fifo_mode_en` differs from the current mode switches the mode. It empties both the holding register and the queue, discards a write made in that cycle, and suppresses `load_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode_en | input | 1 | 1 selects 16-deep queue mode, 0 selects single holding register |
| thr_wr | input | 1 | Processor write strobe for a transmit character |
| thr_wdata | input | 8 | Character written with `thr_wr` |
| txf_clear | input | 1 | Transmit queue flush pulse (queue mode only) |
| irq_en | input | 1 | Enable for the request interrupt |
| shift_done | input | 1 | Serializer reports the shift register has emptied |
| load_valid | output | 1 | Head character is moved to the shift register this cycle |
| load_data | output | 8 | Character being moved when `load_valid` is 1 |
| lsr | output | 8 | Status byte: bit 6 idle, bit 5 request, others 0 |
| tx_empty | output | 1 | Store and shift register both empty |
| tx_req | output | 1 | Ready to accept transmit data |
| irq | output | 1 | Request interrupt |
| dma_req | output | 1 | DMA request for transmit data |

## Verification
The hardest states to reach are a full queue that receives more writes, and a flush that arrives while the shift register is still busy. Random `shift_done` rarely stays low long enough for a full queue to build up. A directed phase therefore switches to queue mode, writes twenty bytes with `shift_done` held low, and then drains with a steady `shift_done`. The random phase after it uses bursty write and completion rates with occasional flushes and mode flips. Every cycle is compared against a reference model that keeps its own queue, holding register and shift-occupancy state.

// File: rtl/uart_txs_pkg.sv
package uart_txs_pkg;

    localparam int LSR_IDLE_BIT = 6;
    localparam int LSR_REQ_BIT  = 5;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_QUEUE  = 1'b1
    } txs_mode_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic clear;
    } store_ctl_t;

    function automatic logic [7:0] pack_status(input logic idle, input logic req);
        logic [7:0] s;
        s = 8'h00;
        s[LSR_IDLE_BIT] = idle;
        s[LSR_REQ_BIT]  = req;
        return s;
    endfunction

endpackage

// File: rtl/uart_txs_queue.sv
module uart_txs_queue
    import uart_txs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  store_ctl_t        ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              full;
    logic              do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = ctl.push && !full && !ctl.clear;
    assign do_pop  = ctl.pop && !empty && !ctl.clear;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (rst)
        (full && ctl.push && !ctl.pop && !ctl.clear) |=> full);

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> empty);

endmodule

// File: rtl/uart_txs_hold.sv
module uart_txs_hold
    import uart_txs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  store_ctl_t        ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic              empty
);
    logic              occupied;
    logic [DATA_W-1:0] value;

    assign head  = value;
    assign empty = !occupied;

    always_ff @(posedge clk) begin
        if (rst) begin
            occupied <= 1'b0;
            value    <= '0;
        end else if (ctl.clear) begin
            occupied <= 1'b0;
        end else if (ctl.push) begin
            occupied <= 1'b1;
            value    <= wdata;
        end else if (ctl.pop) begin
            occupied <= 1'b0;
        end
    end

    assert_write_fills_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.push && !ctl.clear) |=> !empty);

    assert_newest_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.push && !ctl.clear) |=> (head == $past(wdata)));

endmodule

// File: rtl/uart_txs_shifttrk.sv
module uart_txs_shifttrk (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic done,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (load) begin
            busy <= 1'b1;
        end else if (done) begin
            busy <= 1'b0;
        end
    end

    assert_load_occupies_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> busy);

    assert_idle_done_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> !busy);

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
    import uart_txs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_mode_en,
    input  logic              thr_wr,
    input  logic [DATA_W-1:0] thr_wdata,
    input  logic              txf_clear,
    input  logic              irq_en,
    input  logic              shift_done,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data,
    output logic [7:0]        lsr,
    output logic              tx_empty,
    output logic              tx_req,
    output logic              irq,
    output logic              dma_req
);
    txs_mode_e         mode_q;
    logic              mode_flip;
    logic              sh_busy;
    logic              q_empty, h_empty, src_empty;
    logic [DATA_W-1:0] q_head, h_head;
    store_ctl_t        q_ctl, h_ctl;

    assign mode_flip = (fifo_mode_en != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_SINGLE;
        end else begin
            mode_q <= fifo_mode_en ? MODE_QUEUE : MODE_SINGLE;
        end
    end

    assign src_empty  = (mode_q == MODE_QUEUE) ? q_empty : h_empty;
    assign load_valid = !src_empty && !sh_busy && !mode_flip;
    assign load_data  = (mode_q == MODE_QUEUE) ? q_head : h_head;

    always_comb begin
        q_ctl.clear = mode_flip || ((mode_q == MODE_QUEUE) && txf_clear);
        q_ctl.push  = (mode_q == MODE_QUEUE) && thr_wr;
        q_ctl.pop   = (mode_q == MODE_QUEUE) && load_valid;
        h_ctl.clear = mode_flip;
        h_ctl.push  = (mode_q == MODE_SINGLE) && thr_wr;
        h_ctl.pop   = (mode_q == MODE_SINGLE) && load_valid;
    end

    uart_txs_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .ctl   (q_ctl),
        .wdata (thr_wdata),
        .head  (q_head),
        .empty (q_empty)
    );

    uart_txs_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .ctl   (h_ctl),
        .wdata (thr_wdata),
        .head  (h_head),
        .empty (h_empty)
    );

    uart_txs_shifttrk u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (load_valid),
        .done (shift_done),
        .busy (sh_busy)
    );

    assign tx_req   = src_empty;
    assign tx_empty = src_empty && !sh_busy;
    assign irq      = tx_req && irq_en;
    assign dma_req  = tx_req;
    assign lsr      = pack_status(tx_empty, tx_req);

    assert_reset_status_R1: assert property (@(posedge clk)
        $past(rst) |-> (lsr == 8'h60 && !load_valid));

    assert_idle_implies_req_R2: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> tx_req);

    assert_write_clears_req_R5: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !mode_flip && !(mode_q == MODE_QUEUE && txf_clear)) |=> !tx_req);

    assert_clear_sets_req_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_QUEUE && txf_clear) |=> tx_req);

    assert_clear_keeps_shift_R7: assert property (@(posedge clk) disable iff (rst)
        (txf_clear && sh_busy && !shift_done) |=> !tx_empty);

    assert_dma_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_req) |-> !dma_req);

    assert_flip_empties_R10: assert property (@(posedge clk) disable iff (rst)
        mode_flip |=> tx_req);

endmodule

// File: tb/uart_tx_status_bench.sv
module uart_tx_status_bench;

    localparam int DW    = 8;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          fifo_mode_en, thr_wr, txf_clear, irq_en, shift_done;
    logic [DW-1:0] thr_wdata;
    logic          load_valid, tx_empty, tx_req, irq, dma_req;
    logic [DW-1:0] load_data;
    logic [7:0]    lsr;

    always #4 clk = ~clk;

    uart_tx_status #(.DATA_W(DW), .DEPTH(DEPTH)) u_uart_tx_status (
        .clk          (clk),
        .rst          (rst),
        .fifo_mode_en (fifo_mode_en),
        .thr_wr       (thr_wr),
        .thr_wdata    (thr_wdata),
        .txf_clear    (txf_clear),
        .irq_en       (irq_en),
        .shift_done   (shift_done),
        .load_valid   (load_valid),
        .load_data    (load_data),
        .lsr          (lsr),
        .tx_empty     (tx_empty),
        .tx_req       (tx_req),
        .irq          (irq),
        .dma_req      (dma_req)
    );

    int total = 0;
    int bad   = 0;
    bit done_flag = 0;

    // reference model state
    logic          m_mode;
    logic [DW-1:0] m_q [DEPTH];
    int            m_cnt;
    logic          m_hfull;
    logic [DW-1:0] m_hdata;
    logic          m_sh;
    string         req_tag;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_src_empty();
        return m_mode ? (m_cnt == 0) : !m_hfull;
    endfunction

    function automatic logic m_ldv(input logic mode_in);
        return !m_src_empty() && !m_sh && (mode_in == m_mode);
    endfunction

    // one cycle: drive inputs after falling edge, compare, advance model
    task automatic step(input logic wr, input logic [DW-1:0] d, input logic clr,
                        input logic dn, input logic mode_in, input logic en);
        logic ldv, req, idle, flip;
        @(negedge clk);
        thr_wr = wr; thr_wdata = d; txf_clear = clr;
        shift_done = dn; fifo_mode_en = mode_in; irq_en = en;
        #1;
        flip = (mode_in != m_mode);
        ldv  = m_ldv(mode_in);
        req  = m_src_empty();
        idle = req && !m_sh;
        check({req_tag, m_mode ? "/R5" : "/R3"}, tx_req, req);
        check("R2 idle", tx_empty, idle);
        check("R2 lsr", lsr, {1'b0, idle, req, 5'b0});
        check("R8 irq", irq, req && en);
        check("R8 dma", dma_req, req);
        check("R9 load_valid", load_valid, ldv);
        if (ldv) check(m_mode ? "R6 order" : "R4 data", load_data, m_mode ? m_q[0] : m_hdata);
        req_tag = "req";
        // model update
        if (flip) begin
            m_cnt = 0; m_hfull = 0; m_mode = mode_in;
            req_tag = "R10";
        end else if (m_mode) begin
            if (clr) begin
                m_cnt = 0;
                req_tag = "R7";
            end else begin
                logic acc;
                acc = wr && (m_cnt < DEPTH);
                if (ldv) begin
                    for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
                    m_cnt--;
                end
                if (acc) begin
                    m_q[m_cnt] = d;
                    m_cnt++;
                end
            end
        end else begin
            if (wr) begin
                m_hfull = 1; m_hdata = d;
            end else if (ldv) begin
                m_hfull = 0;
            end
        end
        if (ldv) m_sh = 1;
        else if (dn) m_sh = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        req_tag = "req";
        rst = 1; thr_wr = 0; thr_wdata = '0; txf_clear = 0;
        shift_done = 0; fifo_mode_en = 0; irq_en = 0;
        m_mode = 0; m_cnt = 0; m_hfull = 0; m_hdata = '0; m_sh = 0;
        for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R1 lsr", lsr, 8'h60);
        check("R1 load_valid", load_valid, 1'b0);
        check("R1 req", tx_req, 1'b1);

        // single-register mode: write, overwrite while shift busy, drain
        step(1, 8'hA1, 0, 0, 0, 1);
        step(0, 8'h00, 0, 0, 0, 1);        // A1 loaded into shift
        step(1, 8'hB2, 0, 0, 0, 1);
        step(1, 8'hC3, 0, 0, 0, 1);        // R4 overwrite
        step(0, 8'h00, 0, 1, 0, 1);        // shift finishes
        step(0, 8'h00, 0, 0, 0, 1);        // C3 loads
        step(0, 8'h00, 1, 1, 0, 1);        // R7 clear ignored in single mode
        step(0, 8'h00, 0, 0, 0, 1);

        // queue mode: flip, overfill with shift stalled, flush while busy
        step(1, 8'h11, 0, 0, 1, 0);        // R10 flip discards write
        for (int i = 0; i < 20; i++) step(1, 8'(8'h20 + i), 0, 0, 1, 1);
        step(0, 8'h00, 0, 1, 1, 1);
        for (int i = 0; i < 20; i++) step(0, 8'h00, 0, 1, 1, 1);
        for (int i = 0; i < 6; i++) step(1, 8'(8'h50 + i), 0, 0, 1, 1);
        step(1, 8'h77, 1, 0, 1, 1);        // R7 flush, write dropped, shift stays busy
        step(0, 8'h00, 0, 0, 1, 1);
        step(0, 8'h00, 0, 1, 1, 1);
        step(0, 8'h00, 0, 0, 1, 1);

        // random phase with bursty rates
        for (int blk = 0; blk < 40; blk++) begin
            int wr_pct, dn_pct;
            wr_pct = $urandom_range(10, 90);
            dn_pct = $urandom_range(5, 80);
            for (int c = 0; c < 60; c++) begin
                logic md;
                md = ($urandom_range(0, 199) == 0) ? !m_mode : m_mode;
                step($urandom_range(0, 99) < wr_pct, 8'($urandom),
                     $urandom_range(0, 39) == 0, $urandom_range(0, 99) < dn_pct,
                     md, 1'($urandom));
            end
        end

        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule